// File: doc/BRIEF.md
# Multiplexed LED and Key Scanner

This block runs a time-multiplexed LED matrix and, on the same wires, a key matrix. Eight segment lines and five common lines light the matrix one digit at a time. A small register file holds the segment pattern for each digit. Each common line is active for one slot, the digits follow in fixed order, and the order wraps after the last digit.

Between two digit slots every common line is off for a short gap. During the gap the segment lines stop carrying display data and serve as key strobes. Each gap handles one pair of segment lines, one line in each half of the gap. At the end of each half the two shared return inputs are sampled. The scan covers all sixteen keys in four gaps.

Each key's raw level passes through a three-scan debounce. The debounced state is presented as a vector. Every change of state sets a sticky event flag, and a host read strobe clears the flags. The lengths of slot and gap are parameters counted in clock cycles.

Top module: `led_key_scanner`

## Requirements
- R1: At most one common output is active at any time. The commons are activated in the order 0,1,2,3,4 and then wrap. Each stays active for exactly SLOT_CYC consecutive cycles.
- R2: Between any two digit slots all common outputs are inactive for exactly GAP_CYC cycles.
- R3: While common d is active, the segment outputs equal the pattern last written to address d. A write to an address of DIG_N or above changes nothing.
- R4: During a gap exactly one segment output is high. It is line 2p in the first half of the gap (GAP_CYC/2 cycles) and line 2p+1 in the rest. The pair number p starts at 0 after reset and advances by one per gap, modulo 4.
- R5: Key k sits at segment line k/2 and return input k%2, so key index = 2*segment + return. A return input is sampled only at the last cycle of a strobe half, and only for the line being strobed.
- R6: A key's debounced state takes a new level only after three consecutive samples of that key show that level. A shorter pulse leaves the state unchanged.
- R7: Every change of a key's debounced state sets that key's event flag. The flag stays set until cleared.
- R8: A read strobe clears all event flags on the next edge. A flag whose key changes state at that same edge stays set.
- R9: Reset drives all segment and common outputs low and clears the key state and the event flags. After reset the first slot uses common 0 and the first gap strobes line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Pattern write enable |
| wr_addr_i | input | 3 | Digit address of the write |
| wr_data_i | input | 8 | Segment pattern, bit i drives segment line i |
| rd_stb_i | input | 1 | Host read of the event flags; clears them |
| ki_i | input | 2 | Key return inputs, active high |
| seg_o | output | 8 | Segment lines, active high |
| com_o | output | 5 | Digit common lines, active high |
| key_o | output | 16 | Debounced key state, bit k = key k pressed |
| evt_o | output | 16 | Sticky per-key change flags |

## Verification
The bench models the key matrix at the pins. It drives the return lines only from the segment strobe currently active in a gap, so a design that strobes the wrong line or numbers keys the wrong way shows the wrong key as pressed. A press held for about one scan tests the debounce: a design that takes fewer than three samples latches the glitch and raises a spurious flag. A monitor checks that the slot and gap lengths are exact and that digits and strobes follow their order; an off-by-one counter or a wrong pair advance shows up there. The bench also writes to addresses above the last digit and resets the block in mid-run with keys held, which catches an unguarded write and state that survives reset.

// File: rtl/lks_pkg.sv
package lks_pkg;
  typedef enum logic {PH_SLOT = 1'b0, PH_GAP = 1'b1} scan_phase_e;
endpackage

// File: rtl/lks_timer.sv
module lks_timer
  import lks_pkg::*;
#(
  parameter int DIG_N    = 5,
  parameter int PAIR_N   = 4,
  parameter int SLOT_CYC = 2000,
  parameter int GAP_CYC  = 60,
  localparam int DIG_W   = $clog2(DIG_N),
  localparam int PAIR_W  = $clog2(PAIR_N),
  localparam int STB_W   = PAIR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  output scan_phase_e       phase_o,
  output logic [DIG_W-1:0]  dig_o,
  output logic [STB_W-1:0]  strobe_o,
  output logic              sample_o
);
  localparam int MAXC  = (SLOT_CYC > GAP_CYC) ? SLOT_CYC : GAP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int HALF  = GAP_CYC / 2;
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF - 1);
  localparam logic [DIG_W-1:0] DIG_LAST  = DIG_W'(DIG_N - 1);
  localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(PAIR_N - 1);

  scan_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DIG_W-1:0]  dig_q, dig_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic              half_b;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    dig_d  = dig_q;
    pair_d = pair_q;
    if (en_i) begin
      if (ph_q == PH_SLOT) begin
        if (cnt_q == SLOT_LAST) begin
          ph_d  = PH_GAP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == GAP_LAST) begin
          ph_d   = PH_SLOT;
          cnt_d  = '0;
          dig_d  = (dig_q == DIG_LAST) ? '0 : dig_q + 1'b1;
          pair_d = (pair_q == PAIR_LAST) ? '0 : pair_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_SLOT;
      cnt_q  <= '0;
      dig_q  <= '0;
      pair_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      dig_q  <= dig_d;
      pair_q <= pair_d;
    end
  end

  assign half_b   = (cnt_q > HALF_LAST);
  assign phase_o  = ph_q;
  assign dig_o    = dig_q;
  assign strobe_o = {pair_q, half_b};
  assign sample_o = en_i && (ph_q == PH_GAP) &&
                    ((cnt_q == HALF_LAST) || (cnt_q == GAP_LAST));

  AST_PHASE_FRESH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> (cnt_q == '0)); // R2

  AST_SLOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_GAP) && ($past(ph_q) == PH_SLOT)) |-> ($past(cnt_q) == SLOT_LAST)); // R1
endmodule

// File: rtl/lks_debounce.sv
module lks_debounce #(
  parameter int DEB_N = 3,
  localparam int CW   = $clog2(DEB_N)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic raw_i,
  output logic state_o,
  output logic change_o
);
  localparam logic [CW-1:0] RUN_LAST = CW'(DEB_N - 1);

  logic          st_q, st_d;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    st_d     = st_q;
    run_d    = run_q;
    change_o = 1'b0;
    if (sample_i) begin
      if (raw_i == st_q) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        st_d     = raw_i;
        run_d    = '0;
        change_o = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      run_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign state_o = st_q;

  AST_STATE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_q) |-> $past(sample_i)); // R6
endmodule

// File: rtl/led_key_scanner.sv
module led_key_scanner
  import lks_pkg::*;
#(
  parameter int SEG_N    = 8,
  parameter int DIG_N    = 5,
  parameter int RET_N    = 2,
  parameter int SLOT_CYC = 2000,
  parameter int GAP_CYC  = 60,
  parameter int DEB_N    = 3,
  localparam int KEY_N   = SEG_N * RET_N,
  localparam int AW      = $clog2(DIG_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [SEG_N-1:0] wr_data_i,
  input  logic             rd_stb_i,
  input  logic [RET_N-1:0] ki_i,
  output logic [SEG_N-1:0] seg_o,
  output logic [DIG_N-1:0] com_o,
  output logic [KEY_N-1:0] key_o,
  output logic [KEY_N-1:0] evt_o
);
  localparam int PAIR_N = SEG_N / 2;
  localparam int STB_W  = $clog2(PAIR_N) + 1;

  logic              run_q;
  scan_phase_e       phase;
  logic [AW-1:0]     dig;
  logic [STB_W-1:0]  strobe;
  logic              sample;
  logic [SEG_N-1:0]  pat_q [DIG_N];
  logic [RET_N-1:0]  ki_s1_q, ki_s2_q;
  logic [KEY_N-1:0]  chg;
  logic [KEY_N-1:0]  evt_q, evt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  lks_timer #(
    .DIG_N(DIG_N), .PAIR_N(PAIR_N), .SLOT_CYC(SLOT_CYC), .GAP_CYC(GAP_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(run_q),
    .phase_o(phase), .dig_o(dig), .strobe_o(strobe), .sample_o(sample)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIG_N; i++) pat_q[i] <= '0;
    end else if (wr_en_i && (int'(wr_addr_i) < DIG_N)) begin
      pat_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_comb begin
    seg_o = '0;
    com_o = '0;
    if (run_q) begin
      if (phase == PH_SLOT) begin
        com_o[dig] = 1'b1;
        seg_o      = pat_q[dig];
      end else begin
        seg_o[strobe] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ki_s1_q <= '0;
      ki_s2_q <= '0;
    end else begin
      ki_s1_q <= ki_i;
      ki_s2_q <= ki_s1_q;
    end
  end

  for (genvar k = 0; k < KEY_N; k++) begin : g_key
    localparam int SEG_IDX = k / RET_N;
    localparam int RET_IDX = k % RET_N;
    lks_debounce #(.DEB_N(DEB_N)) u_deb (
      .clk(clk), .rst_n(rst_n),
      .sample_i(sample && (strobe == STB_W'(SEG_IDX))),
      .raw_i(ki_s2_q[RET_IDX]),
      .state_o(key_o[k]),
      .change_o(chg[k])
    );
  end

  always_comb begin
    evt_d = (rd_stb_i ? '0 : evt_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_o)); // R1

  AST_GAP_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (com_o == '0)) |-> ($countones(seg_o) == 1)); // R4

  AST_READ_LEAVES_NEW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> ((evt_o & ~(key_o ^ $past(key_o))) == '0)); // R8

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_o != $past(key_o)) |-> ((evt_o & (key_o ^ $past(key_o))) == (key_o ^ $past(key_o)))); // R7
endmodule

// File: tb/test_led_key_scanner.sv
module test_led_key_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 8;
  localparam int GAP  = 6;
  localparam int SCAN = 4 * (SLOT + GAP);
  localparam int SETTLE = 5 * SCAN;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        rd_stb;
  logic [1:0]  ki;
  logic [7:0]  seg;
  logic [4:0]  com;
  logic [15:0] key;
  logic [15:0] evt;

  int checks = 0;
  int errors = 0;

  logic [7:0]  pat_m [5];
  logic [15:0] press_m;
  logic [15:0] key_exp;
  logic [15:0] evt_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_key_scanner #(.SLOT_CYC(SLOT), .GAP_CYC(GAP)) i_led_key_scanner (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_stb_i(rd_stb), .ki_i(ki),
    .seg_o(seg), .com_o(com), .key_o(key), .evt_o(evt)
  );

  // key matrix model: key 2*s+r joins segment s to return r
  always_comb begin
    ki = '0;
    if (com == '0) begin
      for (int s = 0; s < 8; s++) begin
        if (seg[s] && press_m[2*s])   ki[0] = 1'b1;
        if (seg[s] && press_m[2*s+1]) ki[1] = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic int onehot_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // output monitor
  bit         started;
  int         exp_dig, exp_stb, run_len, gaps_seen;
  logic [4:0] prev_com;
  logic [7:0] prev_seg;

  always @(negedge clk) begin
    if (!rst_n) begin
      started = 0; exp_dig = 0; exp_stb = 0; run_len = 0; gaps_seen = 0;
      prev_com = '0; prev_seg = '0;
    end else begin
      if (com != '0) started = 1;
      if (started) begin
        if (com != '0) begin
          chk($countones(com) == 1, "R1 single common", 32'(com), 32'(1));
          if (prev_com == '0) begin
            chk(onehot_idx({3'b0, com}) == exp_dig, "R1 R9 digit order", 32'(onehot_idx({3'b0, com})), 32'(exp_dig));
            if (gaps_seen > 0) chk(run_len == GAP, "R2 gap length", 32'(run_len), 32'(GAP));
            exp_dig = (exp_dig + 1) % 5;
            run_len = 0;
          end
          run_len++;
          if (onehot_idx({3'b0, com}) >= 0)
            chk(seg == pat_m[onehot_idx({3'b0, com})], "R3 segment pattern", 32'(seg), 32'(pat_m[onehot_idx({3'b0, com})]));
        end else begin
          if (prev_com != '0) begin
            chk(run_len == SLOT, "R1 slot length", 32'(run_len), 32'(SLOT));
            run_len = 0;
            gaps_seen++;
          end
          run_len++;
          chk($countones(seg) == 1, "R4 one strobe", 32'(seg), 32'(0));
          if (prev_com != '0 || seg != prev_seg) begin
            chk(onehot_idx(seg) == exp_stb, "R4 strobe order", 32'(onehot_idx(seg)), 32'(exp_stb));
            exp_stb = (exp_stb + 1) % 8;
          end
        end
      end
      prev_com = com;
      prev_seg = seg;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_pat(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (a < 5) pat_m[a] = d;
    #1;
    wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [15:0] exp_flags, input string req);
    @(negedge clk);
    chk(evt == exp_flags, req, 32'(evt), 32'(exp_flags));
    @(posedge clk); #1;
    rd_stb = 1'b1;
    @(posedge clk); #1;
    rd_stb = 1'b0;
    evt_exp = '0;
    @(negedge clk);
    chk(evt == 16'h0, "R8 flags cleared by read", 32'(evt), 32'(0));
  endtask

  task automatic set_keys(input logic [15:0] p);
    evt_exp = evt_exp | (key_exp ^ p);
    key_exp = p;
    press_m = p;
    wait_cyc(SETTLE);
    @(negedge clk);
    chk(key == key_exp, "R5 R6 debounced key state", 32'(key), 32'(key_exp));
    chk(evt == evt_exp, "R7 sticky change flags", 32'(evt), 32'(evt_exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(seg == 8'h0 && com == 5'h0, "R9 outputs quiet in reset", 32'({seg, com}), 32'(0));
    chk(key == 16'h0 && evt == 16'h0, "R9 key state cleared", 32'({key, evt}), 32'(0));
    wait_cyc(3);
    for (int i = 0; i < 5; i++) pat_m[i] = '0;
    key_exp = '0; evt_exp = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_stb = 1'b0;
    press_m = '0; key_exp = '0; evt_exp = '0;
    for (int i = 0; i < 5; i++) pat_m[i] = '0;
    wait_cyc(2);
    do_reset();

    for (int i = 0; i < 5; i++) write_pat(3'(i), 8'($urandom));
    // out-of-range addresses must not disturb any digit (R3)
    for (int a = 5; a < 8; a++) write_pat(3'(a), 8'($urandom));
    wait_cyc(2 * SCAN);

    // corners of the matrix: key 0 (seg0/ret0) and key 15 (seg7/ret1)
    set_keys(16'h8001);
    host_read(16'h8001, "R7 flags after first press");
    // short pulse on key 6 must be filtered (R6)
    press_m = 16'h8041;
    wait_cyc(SCAN + 4);
    press_m = 16'h8001;
    wait_cyc(SETTLE);
    @(negedge clk);
    chk(key == 16'h8001, "R6 short pulse ignored", 32'(key), 32'(16'h8001));
    chk(evt == 16'h0, "R6 no flag from short pulse", 32'(evt), 32'(0));
    set_keys(16'h0000);
    host_read(16'h8001, "R7 flags after release");

    for (int it = 0; it < 16; it++) begin
      if ($urandom % 3 == 0) write_pat(3'($urandom), 8'($urandom));
      set_keys(16'($urandom));
      if ($urandom % 2 == 0) host_read(evt_exp, "R8 flags before read");
    end

    // reset in mid-run with keys held
    press_m = 16'h5a5a;
    key_exp = 16'h5a5a;
    wait_cyc(SETTLE);
    do_reset();
    press_m = '0;
    wait_cyc(2 * SCAN);
    @(negedge clk);
    chk(key == 16'h0 && evt == 16'h0, "R9 state after reset", 32'({key, evt}), 32'(0));
    for (int i = 0; i < 5; i++) write_pat(3'(i), 8'($urandom));
    set_keys(16'h0240);
    wait_cyc(SCAN);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule